// File: doc/BRIEF.md
# Panel Pixel Refill Buffer

This block sits between a burst-capable memory read port and the pixel output of a flat panel. It holds a five-word buffer of frame-buffer data. When the buffer runs down to a single word it asks the memory side for a four-word burst. The memory side may take any number of cycles to grant that request. Each stored 32-bit word is cut into pixels according to the selected colour depth, and one pixel is delivered for every pixel-clock tick that has data behind it.

When a tick arrives and no word is ready, the block keeps the pixel enable low, so no stale or repeated pixel reaches the panel. It also records the event in a sticky flag. A synchronous flush empties the buffer and abandons a partly used word. The depth selection may only change together with a flush.

Top module: `lcd_pixel_fifo`

## Requirements
- R1: While rst_ni is low, req_o, pix_en_o and underflow_o are 0, and the buffer is empty.
- R2: With no burst outstanding, req_o goes high one cycle after the buffer occupancy has dropped to one word or less, so occupancy is at most one when req_o rises.
- R3: req_o stays high until ack_i is sampled high. No new request is raised from that acknowledge until the fourth word of the burst has been written.
- R4: After an acknowledge, exactly the next four cycles with wvalid_i high write wdata_i into the buffer, in arrival order. wvalid_i outside a burst is ignored.
- R5: The buffer holds five words. A burst always fits, so a buffer refilled from one word delivers five words of pixels before it runs dry.
- R6: mode_i=0 (4 bpp) yields 8 pixels per word. Pixel k is bits [4k+3:4k], zero-extended to 16 bits, taken from the least significant end first.
- R7: mode_i=1 (8 bpp) yields 4 pixels per word. Pixel k is bits [8k+7:8k], zero-extended.
- R8: mode_i=2 (12 bpp) yields 2 pixels per word: bits [11:0] and then bits [27:16]. Bits [15:12] and [31:28] are ignored and the output's top four bits are 0.
- R9: mode_i=3 (16 bpp) yields 2 pixels per word: bits [15:0] and then bits [31:16].
- R10: A pix_tick_i sampled while data is present makes pix_en_o high in the next cycle, with the pixel on pix_o. A word leaves the buffer after its last pixel.
- R11: A pix_tick_i sampled while the buffer is empty produces no pixel: pix_en_o stays low and no pixel position is skipped.
- R12: underflow_o is set by every stalled tick and holds until a cycle with uf_clr_i high and no stall. A stall in the same cycle wins over the clear.
- R13: flush_i discards all stored words and any partly used word. The words of a burst requested or in flight at the flush are dropped. mode_i may change only in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous discard of buffer contents |
| mode_i | input | 2 | Colour depth: 0=4, 1=8, 2=12, 3=16 bpp |
| req_o | output | 1 | Burst refill request |
| ack_i | input | 1 | Request granted |
| wvalid_i | input | 1 | Burst word valid |
| wdata_i | input | 32 | Burst word |
| pix_tick_i | input | 1 | Pixel-clock tick wanting a pixel |
| pix_o | output | 16 | Pixel value |
| pix_en_o | output | 1 | Pixel-clock enable, pixel valid |
| underflow_o | output | 1 | Sticky stall flag |
| uf_clr_i | input | 1 | Clear for underflow_o |

## Verification
A pixel is due on the cycle after the tick that asks for it. The bench drives every input on the falling edge and reads outputs on the next falling edge, after the registered pixel stage has updated. A burst word becomes readable one cycle after its wvalid_i. A request appears two edges after the pop that brings occupancy down to one, so the bench checks occupancy at the rising edge of req_o using its own count of delivered words minus words consumed. Latency-sensitive cases (tick-to-enable, drain of a full buffer, stall, flag clear) are stepped tick by tick. The bench counts enables against a scoreboard queue filled by the memory model.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;
  localparam int WORD_W    = 32;
  localparam int PIX_W     = 16;
  localparam int FIFO_DEPTH = 5;
  localparam int BURST_LEN = 4;
  localparam int LOW_WATER = 1;

  typedef enum logic [1:0] {
    BPP4  = 2'd0,
    BPP8  = 2'd1,
    BPP12 = 2'd2,
    BPP16 = 2'd3
  } depth_e;
endpackage

// File: rtl/pix_word_fifo.sv
module pix_word_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) wptr_q <= nxt(wptr_q);
      if (rd_i) rptr_q <= nxt(rptr_q);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |-> (cnt_q < CW'(DEPTH)));
  assert_no_underrun_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/pix_refill_ctrl.sv
module pix_refill_ctrl #(
  parameter int BURST = 4,
  parameter int LOW   = 1,
  parameter int CW    = 3,
  localparam int BW   = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [CW-1:0] count_i,
  input  logic          ack_i,
  input  logic          wvalid_i,
  output logic          req_o,
  output logic          wr_o
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} st_e;
  st_e           st_q;
  logic [BW-1:0] beat_q;
  logic          drop_q;   // burst belongs to flushed contents

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      beat_q <= '0;
      drop_q <= 1'b0;
    end else begin
      if (flush_i && st_q != S_IDLE) drop_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (count_i <= CW'(LOW)) st_q <= S_REQ;
        S_REQ: if (ack_i) begin
          st_q   <= S_FILL;
          beat_q <= '0;
        end
        S_FILL: if (wvalid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == BW'(BURST - 1)) begin
            st_q   <= S_IDLE;
            drop_q <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_o = (st_q == S_REQ);
  assign wr_o  = (st_q == S_FILL) && wvalid_i && !drop_q && !flush_i;

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  assert_req_low_water_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> ($past(count_i) <= CW'(LOW)));
endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import lcd_pix_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int PW = PIX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  depth_e        mode_i,
  input  logic          tick_i,
  input  logic          empty_i,
  input  logic [W-1:0]  word_i,
  output logic          rd_o,
  output logic          stall_o,
  output logic [PW-1:0] pix_o,
  output logic          pix_en_o
);
  logic [2:0]    idx_q;
  logic [2:0]    last_idx;
  logic [PW-1:0] pix_d, pix_q;
  logic          en_q, take;

  always_comb begin
    unique case (mode_i)
      BPP4:    last_idx = 3'd7;
      BPP8:    last_idx = 3'd3;
      default: last_idx = 3'd1;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      BPP4:    pix_d = PW'(word_i[{idx_q, 2'b00} +: 4]);
      BPP8:    pix_d = PW'(word_i[{idx_q[1:0], 3'b000} +: 8]);
      BPP12:   pix_d = PW'(word_i[{idx_q[0], 4'b0000} +: 12]);
      default: pix_d = PW'(word_i[{idx_q[0], 4'b0000} +: 16]);
    endcase
  end

  assign take    = tick_i && !empty_i && !flush_i;
  assign rd_o    = take && (idx_q == last_idx);
  assign stall_o = tick_i && empty_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      en_q  <= 1'b0;
      pix_q <= '0;
    end else if (flush_i) begin
      idx_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= take;
      if (take) begin
        pix_q <= pix_d;
        idx_q <= rd_o ? 3'd0 : idx_q + 3'd1;
      end
    end
  end

  assign pix_o    = pix_q;
  assign pix_en_o = en_q;

  assert_stall_no_pixel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && empty_i) |=> !pix_en_o);
  assert_idx_in_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    idx_q <= last_idx);
  assert_pad_12bpp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && mode_i == BPP12) |-> (pix_o[15:12] == 4'h0));
endmodule

// File: rtl/lcd_pixel_fifo.sv
module lcd_pixel_fifo
  import lcd_pix_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int BURST = BURST_LEN,
  parameter int LOW   = LOW_WATER,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [1:0]        mode_i,
  output logic              req_o,
  input  logic              ack_i,
  input  logic              wvalid_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pix_tick_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_en_o,
  output logic              underflow_o,
  input  logic              uf_clr_i
);
  logic              wr, rd, empty, stall;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     cnt;
  logic              uf_q;

  pix_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) i_fifo (
    .clk_i, .rst_ni, .flush_i,
    .wr_i(wr), .wdata_i, .rd_i(rd),
    .rdata_o(head), .empty_o(empty), .count_o(cnt)
  );

  pix_refill_ctrl #(.BURST(BURST), .LOW(LOW), .CW(CW)) i_ctrl (
    .clk_i, .rst_ni, .flush_i,
    .count_i(cnt), .ack_i, .wvalid_i,
    .req_o, .wr_o(wr)
  );

  pix_unpacker #(.W(WORD_W), .PW(PIX_W)) i_unpack (
    .clk_i, .rst_ni, .flush_i,
    .mode_i(depth_e'(mode_i)), .tick_i(pix_tick_i),
    .empty_i(empty), .word_i(head),
    .rd_o(rd), .stall_o(stall), .pix_o, .pix_en_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       uf_q <= 1'b0;
    else if (stall)    uf_q <= 1'b1;
    else if (uf_clr_i) uf_q <= 1'b0;
  end
  assign underflow_o = uf_q;

  assert_refill_fits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (32'(cnt) + BURST <= DEPTH));
  assert_underflow_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !uf_clr_i) |=> underflow_o);
endmodule

// File: tb/test_lcd_pixel_fifo.sv
module test_lcd_pixel_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [1:0]  mode_i = 2'd1;
  logic        req_o, ack_i = 1'b0, wvalid_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        man_tick = 1'b0, auto_tick = 1'b0;
  wire         pix_tick_i = man_tick | auto_tick;
  logic [15:0] pix_o;
  logic        pix_en_o, underflow_o;
  logic        uf_clr_i = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lcd_pixel_fifo i_lcd_pixel_fifo (
    .clk_i(clk), .rst_ni(rst_n), .flush_i, .mode_i, .req_o, .ack_i,
    .wvalid_i, .wdata_i, .pix_tick_i, .pix_o, .pix_en_o,
    .underflow_o, .uf_clr_i
  );

  int compared = 0, mismatched = 0;
  int words_in = 0, words_out = 0, pix_cnt = 0, pc = 0;
  int lat = 3, gap = 0, tick_mode = 0, cyc = 0;
  bit busy = 0, discard = 0, prev_req = 0;
  string cur_req = "R7";
  logic [15:0] expq[$];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic int ppw(logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 4 : 2;
  endfunction

  function automatic void push_word(logic [31:0] w);
    for (int k = 0; k < ppw(mode_i); k++) begin
      case (mode_i)
        2'd0: expq.push_back({12'h0, w[4*k +: 4]});
        2'd1: expq.push_back({8'h0, w[8*k +: 8]});
        2'd2: expq.push_back({4'h0, w[16*k +: 12]});
        default: expq.push_back(w[16*k +: 16]);
      endcase
    end
  endfunction

  // tick generator
  initial forever begin
    @(negedge clk);
    cyc++;
    auto_tick = (tick_mode == 1) || (tick_mode == 2 && (cyc % 3) == 0);
  end

  // memory model: driver side of the scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && req_o) begin
      int l;
      l = lat;
      busy = 1;
      for (int i = 0; i < l; i++) begin
        @(negedge clk);
        if (!req_o) chk("R3 req held until ack", req_o, 1);
      end
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      for (int b = 0; b < 4; b++) begin
        for (int g = 0; g < gap + (b % 2); g++) begin
          @(negedge clk);
          if (req_o) chk("R3 no request inside burst", req_o, 0);
        end
        seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
        wvalid_i = 1'b1;
        wdata_i  = seed;
        if (!discard) begin
          push_word(seed);
          words_in++;
        end
        @(negedge clk);
        wvalid_i = 1'b0;
        if (req_o) chk("R3 no request inside burst", req_o, 0);
      end
      discard = 0;
      busy = 0;
    end
  end

  // monitor: compares produced pixels against the queue
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (req_o && !prev_req)
        chk("R2 occupancy at request <= 1", 32'((words_in - words_out) <= 1), 1);
      prev_req = req_o;
      if (pix_en_o) begin
        pix_cnt++;
        if (expq.size() == 0) begin
          chk({cur_req, " unexpected pixel"}, 32'(pix_o), 32'hFFFF_FFFF);
        end else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk({cur_req, " pixel"}, 32'(pix_o), 32'(e));
        end
        pc++;
        if (pc == ppw(mode_i)) begin
          pc = 0;
          words_out++;
        end
      end
    end
  end

  task automatic wait_idle();
    int st;
    tick_mode = 0;
    st = 0;
    while (st < 4) begin
      @(negedge clk);
      st = (busy || req_o) ? 0 : st + 1;
    end
  endtask

  task automatic do_flush(logic [1:0] m);
    @(negedge clk);
    flush_i = 1'b1;
    mode_i  = m;
    expq.delete();
    if (busy) discard = 1;
    words_out = words_in;
    pc = 0;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic tick_one();
    @(negedge clk);
    man_tick = 1'b1;
    @(negedge clk);
    man_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 req_o in reset", 32'(req_o), 0);
    chk("R1 pix_en_o in reset", 32'(pix_en_o), 0);
    chk("R1 underflow_o in reset", 32'(underflow_o), 0);
    rst_n = 1'b1;

    // R7: 8 bpp stream, sparse and dense ticks
    cur_req = "R7";
    base = pix_cnt;
    tick_mode = 2;
    repeat (200) @(negedge clk);
    lat = 1; gap = 1; tick_mode = 1;
    repeat (200) @(negedge clk);
    wait_idle();
    chk("R7 pixels produced", 32'(pix_cnt > base), 1);

    // R10: tick-to-enable latency
    cur_req = "R10";
    @(negedge clk);
    man_tick = 1'b1;
    @(negedge clk);
    man_tick = 1'b0;
    chk("R10 pix_en_o one cycle after tick", 32'(pix_en_o), 1);
    @(negedge clk);
    chk("R10 pix_en_o drops without tick", 32'(pix_en_o), 0);

    // R5: refill from one word, drain five words with memory held off
    cur_req = "R5";
    lat = 2; gap = 0;
    while ((words_in - words_out) > 1) tick_one();
    wait_idle();
    lat = 1000;
    base = pix_cnt;
    @(negedge clk);
    man_tick = 1'b1;
    repeat (5 * 4 + 8) @(negedge clk);
    man_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 five words drained", 32'(pix_cnt - base), 20);
    chk("R11 no pixel while empty", 32'(pix_en_o), 0);
    chk("R12 underflow set by stall", 32'(underflow_o), 1);
    lat = 3;
    wait_idle();
    chk("R12 underflow sticky", 32'(underflow_o), 1);
    @(negedge clk);
    uf_clr_i = 1'b1;
    @(negedge clk);
    uf_clr_i = 1'b0;
    chk("R12 underflow cleared", 32'(underflow_o), 0);
    cur_req = "R11";
    tick_mode = 2;
    repeat (60) @(negedge clk);

    // R4: stray word outside a burst is ignored
    wait_idle();
    cur_req = "R4";
    @(negedge clk);
    wvalid_i = 1'b1;
    wdata_i  = 32'hDEAD_BEEF;
    @(negedge clk);
    wvalid_i = 1'b0;
    tick_mode = 2;
    repeat (150) @(negedge clk);

    // R6 / R8 / R9: other depths
    wait_idle();
    do_flush(2'd0);
    cur_req = "R6";
    base = pix_cnt;
    tick_mode = 2;
    repeat (200) @(negedge clk);
    wait_idle();
    chk("R6 pixels produced", 32'(pix_cnt > base), 1);

    do_flush(2'd2);
    cur_req = "R8";
    base = pix_cnt;
    tick_mode = 2;
    repeat (200) @(negedge clk);
    wait_idle();
    chk("R8 pixels produced", 32'(pix_cnt > base), 1);

    do_flush(2'd3);
    cur_req = "R9";
    base = pix_cnt;
    tick_mode = 2;
    repeat (200) @(negedge clk);
    wait_idle();
    chk("R9 pixels produced", 32'(pix_cnt > base), 1);

    // R13: flush with a partly used word, then during an outstanding request
    cur_req = "R13";
    tick_one();
    do_flush(2'd3);
    tick_mode = 2;
    repeat (100) @(negedge clk);
    wait_idle();
    lat = 40;
    do_flush(2'd1);
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
    lat = 3;
    do_flush(2'd1);
    base = pix_cnt;
    tick_mode = 2;
    repeat (200) @(negedge clk);
    wait_idle();
    chk("R13 stream resumes after discard", 32'(pix_cnt > base), 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule